// File: doc/BRIEF.md
# Byte-wide parallel port with per-bit direction and edge interrupt

This block is a parallel I/O port for an 8-bit processor bus. It has one pin group whose bits are each driven or released under a direction mask, and one control register. The port sits at two bus offsets. Offset 1 always reaches the control register. Offset 0 reaches either the direction mask or the data latch, chosen by a steering bit in the control register. Each pin follows its own direction bit, so any mix of inputs and outputs is legal.

The port also watches one interrupt input. An edge of that input, of a polarity chosen in the control register, sets a flag. The flag passes through a two-stage synchroniser before software sees it. When it is enabled, it pulls an active-low request line. Reading the data latch clears the flag. The control register also drives an auxiliary output line. All logic runs on the one bus clock.

Top module: `dport_top`

## Requirements
- R1: Synchronous reset (rst high) clears the data latch, the direction mask and the control register. After reset `pin_oe` is 0, `irq_n` is 1, `aux_oe` is 0, and a control read returns 0x30.
- R2: Control bit 2 steers offset 0. When it is 0, offset 0 accesses the direction mask. When it is 1, offset 0 accesses the data latch. Offset 1 always accesses the control register.
- R3: `pin_oe[i]` equals direction bit i, and `pin_out` equals the data latch. Writing 0x00 to the mask makes all pins inputs.
- R4: A data read returns, for each bit, the latch value where the direction bit is 1 and the `pin_in` level where it is 0.
- R5: A control read returns the bits in this order:
  - bit 7: the synchronised flag
  - bits 6:4: the constant 3'b011
  - bit 3: the auxiliary level
  - bit 2: the steering bit
  - bit 1: the edge polarity
  - bit 0: the interrupt enable
- R6: Control bit 5 drives `aux_oe`, and control bit 3 drives `aux_out`. Writing 0x30 or 0x34 makes the auxiliary line an output held low.
- R7: With polarity 0, a falling edge of `irq_in` sets the flag. With polarity 1, a rising edge sets it. A steady level never sets it.
- R8: A read of the data latch clears the flag. A read of the direction mask or of the control register does not clear it.
- R9: The flag reaches control bit 7 through two register stages. `irq_n` is low only when the synchronised flag is set and the enable is 1. Clearing the enable releases `irq_n` and keeps the flag.
- R10: Bus accesses take effect only while `cs` is high. Read data appears on `rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Port select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| sel | input | 1 | Offset: 0 = mask or data latch, 1 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin drive enable |
| irq_in | input | 1 | Edge interrupt input |
| aux_out | output | 1 | Auxiliary line level |
| aux_oe | output | 1 | Auxiliary line drive enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check on every cycle that:
- writes land in the mask or the latch as the steering bit chooses;
- the constant bits of a control read hold;
- `irq_n` never falls without the enable set;
- a data read with no coincident edge leaves the flag clear.

Only the bench's scenarios can show certain behaviours. These are the mixed-direction read-back under random masks and pin levels, the edge polarity choice, and the exact synchroniser latency. They also include the fact that mask reads and disabling the enable leave a pending flag in place.

// File: rtl/dport_pkg.sv
package dport_pkg;
  localparam int CTL_EN    = 0;
  localparam int CTL_POL   = 1;
  localparam int CTL_DSEL  = 2;
  localparam int CTL_AUXLV = 3;
  localparam int CTL_AUXOE = 5;
  localparam int CTL_FLAG  = 7;
  localparam logic [2:0] CTL_FIXED = 3'b011;

  typedef struct packed {
    logic aux_oe;
    logic aux_lv;
    logic dsel;
    logic pol;
    logic en;
  } ctl_t;
endpackage

// File: rtl/dport_regs.sv
module dport_regs
  import dport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             wr,
  input  logic             sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] ddr,
  output logic [WIDTH-1:0] dat,
  output ctl_t             ctl
);
  logic wr_ctl, wr_ddr, wr_dat;

  always_comb begin
    wr_ctl = cs && wr && sel;
    wr_ddr = cs && wr && !sel && !ctl.dsel;
    wr_dat = cs && wr && !sel && ctl.dsel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ddr <= '0;
      dat <= '0;
      ctl <= '0;
    end else begin
      if (wr_ddr) ddr <= wdata;
      if (wr_dat) dat <= wdata;
      if (wr_ctl) begin
        ctl.aux_oe <= wdata[CTL_AUXOE];
        ctl.aux_lv <= wdata[CTL_AUXLV];
        ctl.dsel   <= wdata[CTL_DSEL];
        ctl.pol    <= wdata[CTL_POL];
        ctl.en     <= wdata[CTL_EN];
      end
    end
  end
endmodule

// File: rtl/dport_pins.sv
module dport_pins #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] ddr,
  input  logic [WIDTH-1:0] dat,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] rd_val
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pin_oe[i]  = ddr[i];
    assign pin_out[i] = dat[i];
    assign rd_val[i]  = ddr[i] ? dat[i] : pin_in[i];
  end
endmodule

// File: rtl/dport_irq.sv
module dport_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic pol,
  input  logic en,
  input  logic clr,
  output logic flag,
  output logic flag_seen,
  output logic irq_n
);
  localparam int LAST = SYNC_STAGES - 1;

  logic smp, smp_q, edge_hit;
  logic [LAST:0] sync_q;

  assign edge_hit  = smp_q && !smp;
  assign flag_seen = sync_q[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      smp   <= 1'b0;
      smp_q <= 1'b0;
      flag  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      smp   <= irq_in ^ pol;
      smp_q <= smp;
      if (edge_hit)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
      irq_n <= !(sync_q[LAST] && en);
    end
  end

  if (SYNC_STAGES == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= flag;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[LAST-1:0], flag};
    end
  end
endmodule

// File: rtl/dport_top.sv
module dport_top
  import dport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             wr,
  input  logic             rd,
  input  logic             sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic             irq_in,
  output logic             aux_out,
  output logic             aux_oe,
  output logic             irq_n
);
  logic [WIDTH-1:0] ddr, dat, rd_val, ctl_rd;
  ctl_t ctl;
  logic flag, flag_seen, clr;

  dport_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .sel(sel), .wdata(wdata),
    .ddr(ddr), .dat(dat), .ctl(ctl)
  );

  dport_pins #(.WIDTH(WIDTH)) u_pins (
    .ddr(ddr), .dat(dat), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .rd_val(rd_val)
  );

  assign clr = cs && rd && !sel && ctl.dsel;

  dport_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst(rst), .irq_in(irq_in), .pol(ctl.pol), .en(ctl.en),
    .clr(clr), .flag(flag), .flag_seen(flag_seen), .irq_n(irq_n)
  );

  assign aux_oe  = ctl.aux_oe;
  assign aux_out = ctl.aux_lv;

  always_comb begin
    ctl_rd = '0;
    ctl_rd[CTL_FLAG]  = flag_seen;
    ctl_rd[6:4]       = CTL_FIXED;
    ctl_rd[CTL_AUXLV] = ctl.aux_lv;
    ctl_rd[CTL_DSEL]  = ctl.dsel;
    ctl_rd[CTL_POL]   = ctl.pol;
    ctl_rd[CTL_EN]    = ctl.en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (cs && rd) begin
      if (sel)           rdata <= ctl_rd;
      else if (ctl.dsel) rdata <= rd_val;
      else               rdata <= ddr;
    end
  end
endmodule

// File: rtl/dport_chk.sv
module dport_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cs,
  input logic             wr,
  input logic             rd,
  input logic             sel,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic             irq_n,
  input logic             dsel,
  input logic             en,
  input logic             flag,
  input logic             irq_in,
  input logic             pol
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && irq_n));

  assert_ddr_write_R2: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && !sel && !dsel) |=> pin_oe == $past(wdata));

  assert_dat_write_R3: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && !sel && dsel) |=> pin_out == $past(wdata));

  assert_ctl_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && sel) |=> rdata[6:4] == 3'b011);

  assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !$past(rst)) |-> $past(en));

  assert_no_write_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr) |=> ($stable(pin_oe) && $stable(pin_out)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !sel && dsel && !$changed(irq_in) && !$changed(pol)) |=>
      (!flag || $past(flag) == 1'b0 && flag));
endmodule

bind dport_top dport_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .sel(sel),
  .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_n(irq_n), .dsel(ctl.dsel), .en(ctl.en), .flag(flag),
  .irq_in(irq_in), .pol(ctl.pol)
);

// File: tb/dport_top_tb.sv
module dport_top_tb;
  logic clk = 0, rst = 1, cs = 0, wr = 0, rd = 0, sel = 0, irq_in = 1;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, pin_out, pin_oe;
  logic aux_out, aux_oe, irq_n;
  int checks = 0, fails = 0;
  logic [7:0] m_ddr, m_dat, rv;
  bit done = 0;

  always #4 clk = ~clk;

  dport_top u_dut (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .sel(sel),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_in(irq_in), .aux_out(aux_out), .aux_oe(aux_oe),
    .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_rd(logic [7:0] d, logic [7:0] m, logic [7:0] p);
    return (d & m) | (p & ~m);
  endfunction

  function automatic logic [7:0] exp_ctl(logic f, logic [7:0] w);
    return {f, 3'b011, w[3:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic s, logic [7:0] d, logic c = 1);
    @(negedge clk); cs = c; wr = 1; sel = s; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(logic s, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; sel = s;
    @(negedge clk); cs = 0; rd = 0; d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    idle(3); rst = 0; idle(1);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 aux_oe", aux_oe, 1'b0);
    bus_rd(1, rv); chk("R1 ctl read", rv, 8'h30);

    // R6 aux configuration
    bus_wr(1, 8'h30);
    chk("R6 aux_oe 0x30", aux_oe, 1'b1); chk("R6 aux_out 0x30", aux_out, 1'b0);
    bus_wr(1, 8'h28); chk("R6 aux_out high", aux_out, 1'b1);
    bus_rd(1, rv); chk("R5 ctl layout", rv, exp_ctl(1'b0, 8'h28));

    // R2/R3/R4 random directions and pins
    for (int it = 0; it < 24; it++) begin
      m_ddr = (it == 0) ? 8'h00 : (it == 1) ? 8'hFF : 8'($urandom);
      m_dat = 8'($urandom);
      bus_wr(1, 8'h30); bus_wr(0, m_ddr);
      bus_wr(1, 8'h34); bus_wr(0, m_dat);
      pin_in = 8'($urandom);
      chk("R3 pin_oe", pin_oe, m_ddr);
      chk("R3 pin_out", pin_out, m_dat);
      bus_rd(0, rv); chk("R4 data read", rv, exp_rd(m_dat, m_ddr, pin_in));
      bus_wr(1, 8'h30); bus_rd(0, rv); chk("R2 mask read", rv, m_ddr);
    end

    // R10 write without cs ignored
    bus_wr(1, 8'h34);
    bus_wr(0, ~m_dat, 1'b0);
    chk("R10 no cs write", pin_out, m_dat);

    // R7/R9 falling edge, polarity 0, enabled
    bus_wr(1, 8'h35);
    irq_in = 1; idle(4);
    irq_in = 0; idle(3);
    chk("R9 latency irq_n still high", irq_n, 1'b1);
    idle(3);
    chk("R7 falling sets irq", irq_n, 1'b0);
    bus_rd(1, rv); chk("R8 ctl read keeps flag", rv[7], 1'b1);
    bus_rd(0, rv); idle(5);
    chk("R8 data read clears", irq_n, 1'b1);
    bus_rd(1, rv); chk("R8 flag clear", rv[7], 1'b0);
    irq_in = 1; idle(6);
    chk("R7 rising ignored pol0", irq_n, 1'b1);
    irq_in = 0; idle(6);
    bus_rd(0, rv); idle(5);

    // R7 polarity 1: rising edge sets
    bus_wr(1, 8'h37); idle(6);
    chk("R7 pol change no edge", irq_n, 1'b1);
    idle(6); chk("R7 level steady", irq_n, 1'b1);
    irq_in = 1; idle(6);
    chk("R7 rising sets pol1", irq_n, 1'b0);

    // R9 disable keeps flag
    bus_wr(1, 8'h36); idle(3);
    chk("R9 disable releases", irq_n, 1'b1);
    bus_rd(1, rv); chk("R9 flag kept", rv[7], 1'b1);
    // R8 mask read does not clear
    bus_wr(1, 8'h32); bus_rd(0, rv); idle(4);
    bus_rd(1, rv); chk("R8 mask read keeps flag", rv[7], 1'b1);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule